// File: doc/BRIEF.md
# Line Draw Engine

This block turns a short set of line parameters into a stream of framebuffer write addresses for a line that is one pixel wide. The caller gives a start point in 16.16 fixed point, a pixel count, two per-pixel increment vectors, an error accumulator setup and a 16-bit on/off mask. The engine then walks the line one pixel per accepted step. Every drawn pixel appears as an address on a valid/ready output. Coordinates only ever move in the positive X and Y directions.

A single datapath serves two drawing methods. With the error accumulator enabled, the engine follows integer error-term stepping: the major axis advances on every pixel, and the minor axis jumps whenever the accumulated error reaches zero or above. With the error add set to zero and a negative start error, no jump is ever taken. The line then advances by a fixed-point slope on every pixel, and the fraction bits give sub-pixel placement. The method is therefore chosen only by how the increment and error values are loaded.

A mask bit of zero skips the write for that pixel, but the position still advances. A solid flag makes every pixel draw. After the programmed number of pixels, the engine pulses a done flag and returns to idle.

Top module: `line_draw_engine`

## Requirements
- R1: After reset, out_valid, busy and done are all low.
- R2: A start pulse while idle captures every parameter input. The first pixel lies at the integer parts of start_x and start_y. Every address is fb_base + y*fb_stride + x, where x and y are bits 31:16 of the positions, computed modulo 2^32.
- R3: After each pixel step the engine forms e' = err + err_add, taken as signed 32-bit values. If e' is not negative, the step also adds jump_dx and jump_dy to the position, and the error becomes e' - err_sub. Otherwise the error becomes e'. In both cases the position then gains run_dx and run_dy.
- R4: With err_add = 0 and a negative err_init, no jump is ever applied. Each position advances by its 16.16 run increment, and the fraction carries from pixel to pixel.
- R5: Pattern bit (k mod 16) decides pixel k, where pixel 0 is the first. When that bit is 0 and solid is low, the pixel raises no out_valid, but its position step and pattern rotation still take place. When solid is high, every pixel is written.
- R6: While out_valid is high and out_ready is low, out_valid and out_addr hold their values.
- R7: The engine makes exactly pix_count pixel steps. Done is high for the single cycle that follows the final step.
- R8: A start with pix_count = 0 raises done in the next cycle and produces no write.
- R9: A start pulse while busy is ignored. The line in progress keeps its captured parameters.
- R10: While busy is low, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line (used only when idle) |
| start_x | input | 32 | Start X, 16.16 fixed point |
| start_y | input | 32 | Start Y, 16.16 fixed point |
| err_init | input | 32 | Initial error accumulator, signed |
| run_dx | input | 32 | X increment applied every pixel, 16.16 |
| run_dy | input | 32 | Y increment applied every pixel, 16.16 |
| jump_dx | input | 32 | Extra X increment when error crosses zero |
| jump_dy | input | 32 | Extra Y increment when error crosses zero |
| err_add | input | 32 | Added to error every pixel, signed |
| err_sub | input | 32 | Subtracted from error on a jump, signed |
| pix_count | input | 16 | Number of pixels in the line |
| pattern | input | 16 | On/off mask, bit 0 first |
| solid | input | 1 | Draw every pixel, ignore mask |
| fb_base | input | 32 | Framebuffer base address |
| fb_stride | input | 16 | Pixels per row |
| out_valid | output | 1 | Pixel write available |
| out_ready | input | 1 | Consumer accepts the write |
| out_addr | output | 32 | Pixel address |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The first pixel is due one cycle after the start edge. It is computed from registered state, with no further delay. Each later pixel is due one cycle after the previous step, where a step is either a handshake or a masked pixel. Done follows the final step by one cycle, and for a zero count it follows the start edge by one cycle. The bench drives inputs and ready on the falling edge and samples out_valid, out_addr and done on that same falling edge. Each sample therefore shows the state left by the preceding rising edge. The bench compares accepted writes in order against a list of addresses that it builds beforehand from the stepping rule.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int CW = 16;
  localparam int FW = 16;
  localparam int PW = CW + FW;
  localparam int EW = 32;
  localparam int AW = 32;

  typedef logic [PW-1:0] fx_t;
  typedef logic [AW-1:0] addr_t;

  function automatic logic [CW-1:0] fx_whole(input fx_t v);
    return v[PW-1:FW];
  endfunction

  function automatic addr_t pix_addr(input addr_t base, input logic [CW-1:0] stride,
                                     input logic [CW-1:0] x, input logic [CW-1:0] y);
    return base + (AW'(y) * AW'(stride)) + AW'(x);
  endfunction

  function automatic logic err_crossed(input logic [EW-1:0] e);
    return ~e[EW-1];
  endfunction
endpackage

// File: rtl/ldr_stepper.sv
module ldr_stepper
  import ldr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  fx_t  [1:0]          start_pos,
  input  fx_t  [1:0]          run_in,
  input  fx_t  [1:0]          jump_in,
  input  logic [EW-1:0]       err_start,
  input  logic [EW-1:0]       err_add_in,
  input  logic [EW-1:0]       err_sub_in,
  output fx_t  [1:0]          pos,
  output logic                minor_take
);
  logic [EW-1:0] err_q, add_q, sub_q, err_acc;

  assign err_acc    = err_q + add_q;
  assign minor_take = err_crossed(err_acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
      add_q <= '0;
      sub_q <= '0;
    end else if (load) begin
      err_q <= err_start;
      add_q <= err_add_in;
      sub_q <= err_sub_in;
    end else if (step) begin
      err_q <= minor_take ? (err_acc - sub_q) : err_acc;
    end
  end

  for (genvar a = 0; a < 2; a++) begin : g_axis
    fx_t pos_q, run_q, jump_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos_q  <= '0;
        run_q  <= '0;
        jump_q <= '0;
      end else if (load) begin
        pos_q  <= start_pos[a];
        run_q  <= run_in[a];
        jump_q <= jump_in[a];
      end else if (step) begin
        pos_q <= pos_q + run_q + (minor_take ? jump_q : '0);
      end
    end
    assign pos[a] = pos_q;
  end
endmodule

// File: rtl/ldr_pattern.sv
module ldr_pattern #(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [PAT_W-1:0] pattern_in,
  input  logic             solid_in,
  output logic             pix_on
);
  logic [PAT_W-1:0] pat_q;
  logic             solid_q;
  logic [PAT_W-1:0] pat_rot;

  if (PAT_W > 1) begin : g_rot
    assign pat_rot = {pat_q[0], pat_q[PAT_W-1:1]};
  end else begin : g_flat
    assign pat_rot = pat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q   <= '0;
      solid_q <= 1'b0;
    end else if (load) begin
      pat_q   <= pattern_in;
      solid_q <= solid_in;
    end else if (step) begin
      pat_q <= pat_rot;
    end
  end

  assign pix_on = solid_q | pat_q[0];
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq #(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] count,
  input  logic          step,
  output logic          load,
  output logic          busy,
  output logic          done
);
  localparam logic [NW-1:0] ONE = NW'(1);
  logic [NW-1:0] remain_q;

  assign load = start & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      remain_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        remain_q <= count;
        if (count == '0) done <= 1'b1;
        else             busy <= 1'b1;
      end else if (step) begin
        remain_q <= remain_q - ONE;
        if (remain_q == ONE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/line_draw_engine.sv
module line_draw_engine
  import ldr_pkg::*;
#(
  parameter int NW    = 16,
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      start_x,
  input  logic [31:0]      start_y,
  input  logic [31:0]      err_init,
  input  logic [31:0]      run_dx,
  input  logic [31:0]      run_dy,
  input  logic [31:0]      jump_dx,
  input  logic [31:0]      jump_dy,
  input  logic [31:0]      err_add,
  input  logic [31:0]      err_sub,
  input  logic [NW-1:0]    pix_count,
  input  logic [PAT_W-1:0] pattern,
  input  logic             solid,
  input  logic [31:0]      fb_base,
  input  logic [15:0]      fb_stride,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_addr,
  output logic             busy,
  output logic             done
);
  logic          load_fire, step_fire, pix_on, minor_take;
  fx_t [1:0]     pos;
  addr_t         base_q;
  logic [CW-1:0] stride_q;
  logic [CW-1:0] cur_x, cur_y;

  ldr_seq #(.NW(NW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .count(pix_count),
    .step(step_fire), .load(load_fire), .busy(busy), .done(done)
  );

  ldr_stepper u_step (
    .clk(clk), .rst_n(rst_n), .load(load_fire), .step(step_fire),
    .start_pos({start_y, start_x}),
    .run_in({run_dy, run_dx}),
    .jump_in({jump_dy, jump_dx}),
    .err_start(err_init), .err_add_in(err_add), .err_sub_in(err_sub),
    .pos(pos), .minor_take(minor_take)
  );

  ldr_pattern #(.PAT_W(PAT_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .load(load_fire), .step(step_fire),
    .pattern_in(pattern), .solid_in(solid), .pix_on(pix_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
    end else if (load_fire) begin
      base_q   <= fb_base;
      stride_q <= fb_stride;
    end
  end

  assign cur_x     = fx_whole(pos[0]);
  assign cur_y     = fx_whole(pos[1]);
  assign out_valid = busy & pix_on;
  assign step_fire = busy & (~pix_on | out_ready);
  assign out_addr  = pix_addr(base_q, stride_q, cur_x, cur_y);
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_fire,
  input logic          step_fire,
  input logic          busy,
  input logic          done,
  input logic          solid,
  input logic [NW-1:0] pix_count,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_addr
);
  logic [NW-1:0] want_q, seen_q;
  logic          solid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_q  <= '0;
      seen_q  <= '0;
      solid_q <= 1'b0;
    end else if (load_fire) begin
      want_q  <= pix_count;
      seen_q  <= '0;
      solid_q <= solid;
    end else if (step_fire) begin
      seen_q <= seen_q + NW'(1);
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_EXACT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> seen_q == want_q); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid); // R10
  AST_SOLID_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && solid_q |-> out_valid); // R5
endmodule

bind line_draw_engine ldr_checker #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .step_fire(step_fire),
  .busy(busy), .done(done), .solid(solid), .pix_count(pix_count),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
);

// File: tb/line_draw_engine_test.sv
module line_draw_engine_test;
  localparam int PERIOD = 10;
  localparam int NV     = 6;
  localparam logic [31:0] BASE   = 32'h1000_0000;
  localparam int          STRIDE = 640;
  // mode(0 err-term,1 pixel-step), solid, x0, y0, dx, dy, count, pattern, ready mask
  localparam int VEC [NV][9] = '{
    '{0, 1,  3,  2,  7,  3,  8, 'h0000, 'hFF},
    '{0, 0, 10,  4,  4,  9, 10, 'hA5C3, 'hB5},
    '{1, 1,  0,  0,  5,  3,  6, 'h0000, 'h6D},
    '{1, 0, 20,  7,  3, 11, 20, 'h0F0F, 'hFF},
    '{0, 1,  1,  1,  4,  0,  5, 'h0000, 'h33},
    '{1, 0,  0,  0, 16, 16, 17, 'h0001, 'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, solid = 1'b0, out_ready = 1'b0;
  logic [31:0] start_x = '0, start_y = '0, err_init = '0, run_dx = '0, run_dy = '0;
  logic [31:0] jump_dx = '0, jump_dy = '0, err_add = '0, err_sub = '0, fb_base = BASE;
  logic [15:0] pix_count = '0, pattern = '0, fb_stride = 16'(STRIDE);
  logic        out_valid, busy, done;
  logic [31:0] out_addr;

  int checks = 0, failures = 0;
  logic [31:0] exp_addr [64];
  int exp_n;

  always #(PERIOD/2) clk = ~clk;

  line_draw_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_x(start_x), .start_y(start_y),
    .err_init(err_init), .run_dx(run_dx), .run_dy(run_dy), .jump_dx(jump_dx),
    .jump_dy(jump_dy), .err_add(err_add), .err_sub(err_sub), .pix_count(pix_count),
    .pattern(pattern), .solid(solid), .fb_base(fb_base), .fb_stride(fb_stride),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_regs(input int v);
    int dx = VEC[v][4], dy = VEC[v][5];
    if (VEC[v][0] == 0) begin
      start_x = VEC[v][2] << 16;
      start_y = VEC[v][3] << 16;
      if (dx >= dy) begin
        run_dx = 32'h1_0000; run_dy = 0; jump_dx = 0; jump_dy = 32'h1_0000;
        err_add = 2*dy; err_sub = 2*dx; err_init = -dx;
      end else begin
        run_dx = 0; run_dy = 32'h1_0000; jump_dx = 32'h1_0000; jump_dy = 0;
        err_add = 2*dx; err_sub = 2*dy; err_init = -dy;
      end
    end else begin
      start_x = (VEC[v][2] << 16) | 'h8000;
      start_y = (VEC[v][3] << 16) | 'h8000;
      jump_dx = 0; jump_dy = 0; err_add = 0; err_sub = 0; err_init = -1;
      if (dx >= dy) begin run_dx = 32'h1_0000; run_dy = (dy << 16) / dx; end
      else          begin run_dy = 32'h1_0000; run_dx = (dx << 16) / dy; end
    end
    solid     = VEC[v][1][0];
    pattern   = 16'(VEC[v][7]);
    pix_count = 16'(VEC[v][6]);
  endtask

  // Model of R2/R3/R4/R5, written from the requirement text.
  task automatic build_expect();
    longint px = start_x, py = start_y;
    int e = int'(err_init);
    exp_n = 0;
    for (int k = 0; k < int'(pix_count); k++) begin
      if (solid || ((pattern >> (k % 16)) & 1)) begin
        exp_addr[exp_n] = BASE + 32'((py >> 16) * STRIDE + (px >> 16));
        exp_n++;
      end
      e = e + int'(err_add);
      if (e >= 0) begin
        px += jump_dx; py += jump_dy;
        e = e - int'(err_sub);
      end
      px += run_dx; py += run_dy;
    end
  endtask

  task automatic run_line(input int v, input bit interfere, input string req);
    int k = 0, cyc = 0;
    bit hit = 0;
    set_regs(v);
    build_expect();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 2000) begin
      out_ready = VEC[v][8][cyc % 8];
      if (out_valid && out_ready) begin
        chk(k < exp_n && out_addr == exp_addr[k], req, $sformatf("vec %0d pixel %0d", v, k),
            out_addr, (k < exp_n) ? exp_addr[k] : 0);
        k++;
      end
      if (start) start = 1'b0;
      if (interfere && k == 2 && !hit) begin
        hit = 1;
        start_x = 32'h0050_0000; pix_count = 16'd3; // R9: must be ignored
        start = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(done, "R7", $sformatf("vec %0d done seen", v), done, 1);
    chk(k == exp_n, interfere ? "R9" : "R7", $sformatf("vec %0d write count", v), k, exp_n);
    @(negedge clk);
    chk(!done, "R7", "done is single cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy && !done, "R1", "reset outputs", {out_valid, busy, done}, 0);

    for (int v = 0; v < NV; v++) begin
      run_line(v, 1'b0, (VEC[v][1] == 0) ? "R5" : (VEC[v][0] == 0) ? "R3" : "R4");
      chk(!out_valid && !busy, "R10", "idle after line", out_valid, 0);
    end

    // R9: start pulse mid-line with altered inputs
    run_line(0, 1'b1, "R9");

    // R8: zero-length line
    pix_count = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !out_valid, "R8", "zero count done", {done, out_valid}, 2);
    @(negedge clk);
    chk(!done && !busy, "R8", "zero count back idle", {done, busy}, 0);

    // R6 and R2: stall on first pixel, address equals start point
    set_regs(0);
    out_ready = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_addr == BASE + 2*STRIDE + 3, "R2", "first pixel address", out_addr, BASE + 2*STRIDE + 3);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      chk(out_valid && out_addr == BASE + 2*STRIDE + 3, "R6", "stall hold", out_addr,
          BASE + 2*STRIDE + 3);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_addr == BASE + 2*STRIDE + 4, "R6", "advance after stall", out_addr, BASE + 2*STRIDE + 4);
    while (!done) @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule